// File: doc/BRIEF.md
# Serial EEPROM Target with One-Byte Offset Resolution

This block sits on a two-wire serial bus as a target and behaves like a small byte-wide EEPROM. A controller writes a two-byte internal offset and then data bytes, or reads bytes starting from the current offset. The target samples the bus clock and data lines on a faster system clock. It finds bus start and stop conditions, compares the device address and acknowledges. It holds a byte memory whose size is a parameter.

The feature that sets it apart is how it handles a read that begins after the controller has sent only one of the two offset bytes. By default the target takes that single byte as the low half of the offset and clears the high half. It treats the offset as complete and then serves ordinary sequential data from there. A mode input selects the older behaviour instead: every byte of such a read comes back as 0xFF and the offset state is not touched. Software that probes the address width of a part can use the difference between these two behaviours.

The data line is open-drain. The block only reports when it wants the line pulled low, and the pad or the bus wiring does the actual pulling.

Top module: `i2c_offset_eeprom`

## Requirements
- R1: After reset the target does not pull SDA low, its internal offset is 0 and its offset-byte count is 0. With the memory-clear option set, every location reads 0x00.
- R2: The target acknowledges its own 7-bit address (bits 7..1 of the address byte, bit 0 = 1 for read) in both directions. It does not acknowledge any other address, and it ignores and stores nothing from the bytes that follow until the next START.
- R3: In a write phase the first byte is the high offset byte and the second is the low byte. The 16-bit offset is reduced modulo MEM_BYTES. Further bytes are stored at successive offsets, and every byte is acknowledged.
- R4: Each byte read returns the memory at the current offset, MSB first, and then advances the offset by one. A controller NACK ends the read, and the target then releases SDA until the next START.
- R5: The offset wraps from MEM_BYTES-1 to 0 on both writes and reads.
- R6: With legacy_fill = 0, a read that begins after exactly one offset byte uses that byte as the low offset and 0x00 as the high offset, reduced modulo MEM_BYTES.
- R7: Once the one-byte case is resolved the offset counts as fully received. Later bytes of the read are sequential, and a later read with no offset bytes continues from there.
- R8: With legacy_fill = 1, a read that begins after exactly one offset byte returns 0xFF for every byte. The offset value and the offset-byte count stay unchanged, so a second such read also returns 0xFF.
- R9: Addressing the device for a write resets the offset-byte count but keeps the offset value. A read addressed with no preceding offset bytes continues from the current offset.
- R10: A STOP (SDA rising while SCL is high) returns the target to idle with SDA released. A repeated START (SDA falling while SCL is high) begins a new address phase at any point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| legacy_fill | input | 1 | 1 = a read after one offset byte returns 0xFF; 0 = low-byte resolution |
| sda_pull | output | 1 | 1 = pull SDA low; 0 = release (high impedance) |

## Verification
The bench runs several kinds of transfer: full two-byte offset writes followed by repeated-start reads, reads with no offset bytes, writes that cross the top of memory, an offset whose high byte exceeds the memory size, and traffic sent to a foreign address. Together these separate correct offset capture, the modulo reduction, wrap-around and address filtering. The one-offset-byte read is issued after a full offset whose high byte is non-zero, so a design that keeps the old high byte gives different data from one that clears it. The same stimulus is repeated with legacy_fill set. After that, an empty write addressing and a plain read show whether the legacy path changed the offset.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_A,
      ST_WBYTE,
      ST_ACK_W,
      ST_RBYTE,
      ST_RACK,
      ST_RACKD
   } bus_st_t;

   typedef enum logic [1:0] {
      OFS_NONE,
      OFS_HALF,
      OFS_FULL
   } ofs_cnt_t;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
      logic sda;
   } bus_evt_t;

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync
   import i2c_ee_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt
);

   logic [STAGES-1:0] scl_sh;
   logic [STAGES-1:0] sda_sh;
   logic              scl_p;
   logic              sda_p;
   logic              scl_s;
   logic              sda_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_p  <= scl_s;
         sda_p  <= sda_s;
      end
   end

   assign scl_s = scl_sh[STAGES-1];
   assign sda_s = sda_sh[STAGES-1];

   always_comb begin
      evt.scl_rise = scl_s & ~scl_p;
      evt.scl_fall = ~scl_s & scl_p;
      evt.start    = scl_s & scl_p & sda_p & ~sda_s;
      evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
      evt.sda      = sda_s;
   end

endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
   parameter int DEPTH = 256,
   parameter int AW    = 8,
   parameter bit CLEAR = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] mem [DEPTH];

   generate
      if (CLEAR) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_ee_offset.sv
module i2c_ee_offset
   import i2c_ee_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          legacy_fill,
   input  logic          wr_hit,
   input  logic          byte_done,
   input  logic [7:0]    rx_byte,
   input  logic          rd_load,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output logic [AW-1:0] mem_raddr,
   output logic          force_ff
);

   localparam logic [AW-1:0] PTR_ONE  = AW'(1);
   localparam logic [AW-1:0] PTR_LAST = '1;

   logic [AW-1:0] offset;
   logic [7:0]    hold;
   ofs_cnt_t      got;
   logic [AW-1:0] hold_eff;
   logic          half_resolve;
   logic          ptr_inc;

   assign hold_eff     = AW'(hold);
   assign half_resolve = (got == OFS_HALF) && !legacy_fill;
   assign force_ff     = (got == OFS_HALF) && legacy_fill;
   assign mem_we       = byte_done && (got == OFS_FULL);
   assign mem_waddr    = offset;
   assign mem_raddr    = half_resolve ? hold_eff : offset;
   assign ptr_inc      = mem_we || (rd_load && (got != OFS_HALF));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         offset <= '0;
         hold   <= 8'h00;
         got    <= OFS_NONE;
      end else if (wr_hit) begin
         got <= OFS_NONE;
      end else if (byte_done) begin
         unique case (got)
            OFS_NONE: begin
               hold <= rx_byte;
               got  <= OFS_HALF;
            end
            OFS_HALF: begin
               offset <= AW'({hold, rx_byte});
               got    <= OFS_FULL;
            end
            default: offset <= offset + PTR_ONE;
         endcase
      end else if (rd_load) begin
         if (got == OFS_HALF) begin
            if (!legacy_fill) begin
               offset <= hold_eff + PTR_ONE;
               got    <= OFS_FULL;
            end
         end else begin
            offset <= offset + PTR_ONE;
         end
      end
   end

   a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      got != 2'd3);

   a_r5_offset_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_inc && offset == PTR_LAST) |=> offset == '0);

   a_r6_half_resolve: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_load && got == OFS_HALF && !legacy_fill)
      |=> (got == OFS_FULL && offset == $past(hold_eff) + PTR_ONE));

   a_r8_legacy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_load && got == OFS_HALF && legacy_fill)
      |=> ($stable(offset) && got == OFS_HALF));

endmodule

// File: rtl/i2c_offset_eeprom.sv
module i2c_offset_eeprom
   import i2c_ee_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h50,
   parameter int         MEM_BYTES   = 256,
   parameter int         SYNC_STAGES = 2,
   parameter bit         MEM_CLEAR   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic legacy_fill,
   output logic sda_pull
);

   localparam int AW = $clog2(MEM_BYTES);

   generate
      if ((1 << AW) != MEM_BYTES) begin : g_bad_size
         $error("MEM_BYTES must be a power of two");
      end
      if (AW < 4 || AW > 16) begin : g_bad_range
         $error("MEM_BYTES must lie between 16 and 65536");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   bus_evt_t      evt;
   bus_st_t       state;
   logic [3:0]    cnt;
   logic [7:0]    shreg;
   logic [7:0]    txreg;
   logic          rw;
   logic          sda_oe_q;

   logic          wr_hit;
   logic          byte_done;
   logic          rd_load;
   logic          addr_match;
   logic          mem_we;
   logic [AW-1:0] mem_waddr;
   logic [AW-1:0] mem_raddr;
   logic [7:0]    mem_rdata;
   logic          force_ff;
   logic [7:0]    load_byte;

   i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .evt   (evt)
   );

   assign addr_match = (shreg[7:1] == DEV_ADDR);
   assign wr_hit     = (state == ST_ADDR) && evt.scl_fall && (cnt == 4'd8)
                       && addr_match && !shreg[0];
   assign byte_done  = (state == ST_WBYTE) && evt.scl_fall && (cnt == 4'd8);
   assign rd_load    = evt.scl_fall
                       && (((state == ST_ACK_A) && rw) || (state == ST_RACKD));
   assign load_byte  = force_ff ? 8'hFF : mem_rdata;

   i2c_ee_offset #(.AW(AW)) u_ofs (
      .clk         (clk),
      .rst_n       (rst_n),
      .legacy_fill (legacy_fill),
      .wr_hit      (wr_hit),
      .byte_done   (byte_done),
      .rx_byte     (shreg),
      .rd_load     (rd_load),
      .mem_we      (mem_we),
      .mem_waddr   (mem_waddr),
      .mem_raddr   (mem_raddr),
      .force_ff    (force_ff)
   );

   i2c_ee_mem #(.DEPTH(MEM_BYTES), .AW(AW), .CLEAR(MEM_CLEAR)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (shreg),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= 4'd0;
         shreg    <= 8'h00;
         txreg    <= 8'h00;
         rw       <= 1'b0;
         sda_oe_q <= 1'b0;
      end else if (evt.start) begin
         state    <= ST_ADDR;
         cnt      <= 4'd0;
         sda_oe_q <= 1'b0;
      end else if (evt.stop) begin
         state    <= ST_IDLE;
         sda_oe_q <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR, ST_WBYTE: begin
               if (evt.scl_rise) begin
                  shreg <= {shreg[6:0], evt.sda};
                  cnt   <= cnt + 4'd1;
               end else if (evt.scl_fall && cnt == 4'd8) begin
                  if (state == ST_WBYTE) begin
                     sda_oe_q <= 1'b1;
                     state    <= ST_ACK_W;
                  end else if (addr_match) begin
                     sda_oe_q <= 1'b1;
                     rw       <= shreg[0];
                     state    <= ST_ACK_A;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_ACK_A, ST_RACKD: begin
               if (evt.scl_fall) begin
                  if (state == ST_RACKD || rw) begin
                     txreg    <= load_byte;
                     sda_oe_q <= ~load_byte[7];
                     cnt      <= 4'd1;
                     state    <= ST_RBYTE;
                  end else begin
                     sda_oe_q <= 1'b0;
                     cnt      <= 4'd0;
                     state    <= ST_WBYTE;
                  end
               end
            end
            ST_ACK_W: begin
               if (evt.scl_fall) begin
                  sda_oe_q <= 1'b0;
                  cnt      <= 4'd0;
                  state    <= ST_WBYTE;
               end
            end
            ST_RBYTE: begin
               if (evt.scl_fall) begin
                  if (cnt == 4'd8) begin
                     sda_oe_q <= 1'b0;
                     state    <= ST_RACK;
                  end else begin
                     sda_oe_q <= ~txreg[3'd7 - cnt[2:0]];
                     cnt      <= cnt + 4'd1;
                  end
               end
            end
            ST_RACK: begin
               if (evt.scl_rise) begin
                  state <= evt.sda ? ST_IDLE : ST_RACKD;
               end
            end
            default: sda_oe_q <= 1'b0;
         endcase
      end
   end

   assign sda_pull = sda_oe_q;

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe_q);

   a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      evt.stop |=> (state == ST_IDLE && !sda_oe_q));

   a_r4_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RACK && evt.scl_rise && evt.sda) |=> state == ST_IDLE);

   a_r10_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
      evt.start |=> (state == ST_ADDR && cnt == 4'd0));

endmodule

// File: tb/sim_i2c_offset_eeprom.sv
module sim_i2c_offset_eeprom;

   localparam int         MEMB = 1024;
   localparam logic [6:0] DEV  = 7'h50;
   localparam int         Q    = 6;

   typedef logic [7:0] bq_t [$];

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic legacy = 1'b0;
   logic sda_pull;
   logic line;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] mm [MEMB];
   int off_m = 0;
   int got_m = 0;
   int hold_m = 0;

   always #2 clk = ~clk;

   assign line = m_sda & ~sda_pull;

   i2c_offset_eeprom #(
      .DEV_ADDR(DEV), .MEM_BYTES(MEMB), .SYNC_STAGES(2), .MEM_CLEAR(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(line),
      .legacy_fill(legacy), .sda_pull(sda_pull)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference model
   task automatic m_addr_wr();
      got_m = 0;
   endtask

   task automatic m_wbyte(input logic [7:0] b);
      if (got_m == 0) begin
         hold_m = b; got_m = 1;
      end else if (got_m == 1) begin
         off_m = ((hold_m << 8) | b) % MEMB; got_m = 2;
      end else begin
         mm[off_m] = b; off_m = (off_m + 1) % MEMB;
      end
   endtask

   task automatic m_rbyte(output logic [7:0] r);
      if (got_m == 1 && legacy) begin
         r = 8'hFF;
      end else begin
         if (got_m == 1) begin
            off_m = hold_m % MEMB; got_m = 2;
         end
         r = mm[off_m];
         off_m = (off_m + 1) % MEMB;
      end
   endtask

   // bus primitives
   task automatic bus_start();
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(Q);
   endtask

   task automatic bit_out(input logic b);
      m_sda = b; tick(Q);
      m_scl = 1'b1; tick(2 * Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bit_in(output logic b);
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      b = line; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic write_byte(input logic [7:0] b, output bit ack);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(a);
      ack = !a;
   endtask

   task automatic read_byte(input bit give_ack, output logic [7:0] b);
      logic x;
      for (int i = 7; i >= 0; i--) begin
         bit_in(x);
         b[i] = x;
      end
      bit_out(!give_ack);
   endtask

   // transactions
   task automatic wr_phase(input bq_t q, input string tag);
      bit ack;
      bus_start();
      write_byte({DEV, 1'b0}, ack);
      chk(ack, {tag, " write address ack (R2)"}, ack, 1);
      m_addr_wr();
      foreach (q[i]) begin
         write_byte(q[i], ack);
         chk(ack, {tag, " byte ack (R3)"}, ack, 1);
         m_wbyte(q[i]);
      end
   endtask

   task automatic rd_phase(input int n, input string tag);
      bit ack;
      logic [7:0] b, e;
      bus_start();
      write_byte({DEV, 1'b1}, ack);
      chk(ack, {tag, " read address ack (R2)"}, ack, 1);
      for (int i = 0; i < n; i++) begin
         read_byte(i != n - 1, b);
         m_rbyte(e);
         chk(b == e, tag, b, e);
      end
      bus_stop();
   endtask

   initial begin : wdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R10 bus progress actual=timeout expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      bit ack;
      for (int i = 0; i < MEMB; i++) mm[i] = 8'h00;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R1: reset state
      chk(sda_pull == 1'b0, "R1 sda released after reset", sda_pull, 0);
      rd_phase(2, "R1 reset contents from offset 0");

      // R3 + R4: full offset write and sequential read back
      wr_phase('{8'h00, 8'h05, 8'hA1, 8'hB2, 8'hC3}, "R3 data write");
      bus_stop();
      wr_phase('{8'h00, 8'h05}, "R3 offset set");
      rd_phase(3, "R4 sequential read");

      // R9: read with no offset continues; write addressing keeps offset
      rd_phase(2, "R9 read continues without offset");
      wr_phase('{}, "R9 empty write");
      bus_stop();
      rd_phase(1, "R9 offset kept after empty write");

      // R2: foreign address ignored
      bus_start();
      write_byte({7'h23, 1'b0}, ack);
      chk(!ack, "R2 foreign address not acked", ack, 0);
      write_byte(8'h00, ack);
      chk(!ack, "R2 foreign byte not acked", ack, 0);
      write_byte(8'h05, ack);
      chk(!ack, "R2 foreign byte not acked", ack, 0);
      write_byte(8'hEE, ack);
      chk(!ack, "R2 foreign byte not acked", ack, 0);
      bus_stop();
      wr_phase('{8'h00, 8'h05}, "R2 offset set");
      rd_phase(3, "R2 memory unchanged by foreign traffic");

      // R5: wrap on write and read
      wr_phase('{8'h03, 8'hFF, 8'h11, 8'h22}, "R5 wrap write");
      bus_stop();
      wr_phase('{8'h03, 8'hFE}, "R5 offset set");
      rd_phase(4, "R5 read wraps past top");

      // R3: offset above memory size reduced modulo
      wr_phase('{8'h14, 8'h04, 8'h5A}, "R3 modulo offset write");
      bus_stop();
      wr_phase('{8'h00, 8'h04}, "R3 offset set");
      rd_phase(1, "R3 modulo offset landed at 0x004");

      // R6 + R7: one offset byte after non-zero high offset
      wr_phase('{8'h02, 8'h10, 8'h77, 8'h78}, "R6 setup high");
      bus_stop();
      wr_phase('{8'h00, 8'h10, 8'h66, 8'h67, 8'h68}, "R6 setup low");
      bus_stop();
      wr_phase('{8'h02, 8'h10}, "R6 non-zero high offset");
      wr_phase('{8'h10}, "R6 single offset byte");
      rd_phase(2, "R6 one-byte offset uses cleared high byte");
      rd_phase(1, "R7 later read continues sequentially");

      // R8: legacy fill
      legacy = 1'b1;
      wr_phase('{8'h10}, "R8 single offset byte");
      rd_phase(2, "R8 legacy read returns FF");
      rd_phase(2, "R8 second legacy read still FF");
      wr_phase('{}, "R8 empty write");
      bus_stop();
      rd_phase(2, "R8 offset unchanged by legacy read");
      legacy = 1'b0;

      // R10: stop releases, new transfer works after a stop mid-byte
      bus_start();
      write_byte({DEV, 1'b0}, ack);
      chk(ack, "R10 address ack before aborted byte", ack, 1);
      m_addr_wr();
      bit_out(1'b1);
      bit_out(1'b0);
      m_scl = 1'b0;
      bus_stop();
      tick(4);
      chk(sda_pull == 1'b0, "R10 sda released after stop", sda_pull, 0);
      wr_phase('{8'h00, 8'h05}, "R10 new transfer after stop");
      rd_phase(2, "R10 read after repeated start");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule